// File: doc/BRIEF.md
# Character Stream Fetch Unit

The unit returns the next byte of a character stream held in 16-bit word-addressed memory. The caller points it at a two-word stream descriptor at an even address and pulses a start strobe. The unit reads the descriptor and reports whether the stream has run out. If it has not, the unit reads the data word that holds the current byte and selects its upper or lower half. It then writes the updated descriptor back to memory and finishes with a one-cycle done pulse. With that pulse it returns the byte, zero-extended to 16 bits, and an exhausted flag.

Descriptor word 0 packs a byte-side flag in bit 15 and a 15-bit count of remaining bytes in bits 14..0. Word 1 holds the address of the data word. Successive fetches alternate between the upper and lower byte of a word. The data address moves to the next word only after the lower byte has been consumed. When the optional fold input is set, lower-case ASCII letters are returned as upper case.

Top module: `char_stream_fetch`

## Requirements
- R1: After reset, done_o and mem_req_o are low.
- R2: After start_i, the unit reads descriptor word 0 at base_addr_i and word 1 at base_addr_i+1. The memory returns read data one cycle after the request.
- R3: If bits 14..0 of word 0 are zero, done_o comes with exhausted_o=1 and char_o=0, and no memory write is made.
- R4: Otherwise word 0 is written back as word0 + 16'h7FFF. This decrements the 15-bit count and inverts bit 15.
- R5: If bit 15 of word 0 is 0, char_o takes bits 15..8 of the data word at the address held in word 1. If bit 15 is 1, char_o takes bits 7..0.
- R6: After a lower-byte fetch (bit 15 = 1), word 1 is written back incremented by one. After an upper-byte fetch, word 1 is not written. An operation makes at most two writes.
- R7: When fold_i is 1 at start, a byte in 8'h61..8'h7A is returned reduced by 8'h20. All other bytes, and all bytes when fold_i is 0, are returned unchanged.
- R8: char_o bits 15..8 are always zero when done_o is high.
- R9: done_o is a single-cycle pulse, one per accepted start. A start_i pulse while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| base_addr_i | input | AW | Even address of the descriptor |
| fold_i | input | 1 | Fold lower case to upper case |
| done_o | output | 1 | Completion pulse |
| exhausted_o | output | 1 | Stream had no bytes left (valid with done_o) |
| char_o | output | DW | Fetched byte, zero-extended (valid with done_o) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after the read request |

## Verification
Faults in the internal state are visible at the ports within one operation, which takes at most seven cycles. A wrong byte-side flag or a wrong captured address shows up as the wrong character on the done pulse, or as a write to the wrong word. A faulty count test shows up as a write, or a missing one, on an empty stream. The bench therefore compares the returned byte and the exhausted flag, the rewritten descriptor words, and the number of writes in every operation. It also steps through one stream until it is empty, so that an error in the carried state becomes visible on the following fetch.

// File: rtl/csf_pkg.sv
package csf_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_CHK, S_RDD, S_WR0, S_WR1, S_FIN
  } csf_state_e;
endpackage

// File: rtl/csf_byte_pick.sv
module csf_byte_pick #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] word_i,
  input  logic          low_i,
  input  logic          fold_i,
  output logic [DW-1:0] char_o
);
  localparam int BW = DW / 2;
  localparam logic [BW-1:0] LO_A  = BW'(8'h61);
  localparam logic [BW-1:0] LO_Z  = BW'(8'h7A);
  localparam logic [BW-1:0] DELTA = BW'(8'h20);

  logic [BW-1:0] byte_sel, byte_out;

  always_comb begin
    byte_sel = low_i ? word_i[BW-1:0] : word_i[DW-1:BW];
    byte_out = byte_sel;
    if (fold_i && byte_sel >= LO_A && byte_sel <= LO_Z) byte_out = byte_sel - DELTA;
    char_o = {{(DW-BW){1'b0}}, byte_out};
  end
endmodule

// File: rtl/csf_desc_update.sv
module csf_desc_update #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] desc0_i,
  input  logic [DW-1:0] waddr_i,
  output logic [DW-1:0] desc0_o,
  output logic [DW-1:0] waddr_o,
  output logic          empty_o
);
  localparam int CW = DW - 1;
  // single add: count-1 and flag toggle together
  localparam logic [DW-1:0] STEP = {1'b0, {CW{1'b1}}};

  assign desc0_o = desc0_i + STEP;
  assign waddr_o = waddr_i + DW'(1);
  assign empty_o = (desc0_i[CW-1:0] == '0);
endmodule

// File: rtl/char_stream_fetch.sv
module char_stream_fetch
  import csf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          fold_i,
  output logic          done_o,
  output logic          exhausted_o,
  output logic [DW-1:0] char_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int FLAG = DW - 1;

  csf_state_e    state_q;
  logic [AW-1:0] base_q;
  logic          fold_q, exh_q;
  logic [DW-1:0] desc0_q, waddr_q, char_q;
  logic [DW-1:0] desc0_nx, waddr_nx, pick;
  logic          empty;

  csf_desc_update #(.DW(DW)) i_upd (
    .desc0_i(desc0_q), .waddr_i(waddr_q),
    .desc0_o(desc0_nx), .waddr_o(waddr_nx), .empty_o(empty)
  );

  csf_byte_pick #(.DW(DW)) i_pick (
    .word_i(mem_rdata_i), .low_i(desc0_q[FLAG]), .fold_i(fold_q), .char_o(pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      fold_q  <= 1'b0;
      exh_q   <= 1'b0;
      desc0_q <= '0;
      waddr_q <= '0;
      char_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          base_q  <= base_addr_i;
          fold_q  <= fold_i;
          state_q <= S_RD0;
        end
        S_RD0: state_q <= S_RD1;
        S_RD1: begin
          desc0_q <= mem_rdata_i;
          state_q <= S_CHK;
        end
        S_CHK: begin
          waddr_q <= mem_rdata_i;
          if (empty) begin
            exh_q   <= 1'b1;
            char_q  <= '0;
            state_q <= S_FIN;
          end else begin
            exh_q   <= 1'b0;
            state_q <= S_RDD;
          end
        end
        S_RDD: state_q <= S_WR0;
        S_WR0: begin
          char_q  <= pick;
          state_q <= desc0_q[FLAG] ? S_WR1 : S_FIN;
        end
        S_WR1: state_q <= S_FIN;
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD0: mem_req_o = 1'b1;
      S_RD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base_q + AW'(1);
      end
      S_RDD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = waddr_q[AW-1:0];
      end
      S_WR0: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = desc0_nx;
      end
      S_WR1: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = base_q + AW'(1);
        mem_wdata_o = waddr_nx;
      end
      default: ;
    endcase
  end

  assign done_o      = (state_q == S_FIN);
  assign exhausted_o = exh_q;
  assign char_o      = char_q;
endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          exhausted_o,
  input logic [DW-1:0] char_o,
  input logic          mem_req_o,
  input logic          mem_we_o
);
  localparam int BW = DW / 2;
  logic [1:0] wr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_cnt <= '0;
    else if (done_o) wr_cnt <= '0;
    else if (mem_we_o && wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_zero_ext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> char_o[DW-1:BW] == '0);
  assert_exh_no_char_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exhausted_o) |-> char_o == '0);
  assert_write_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> wr_cnt < 2'd2);
  assert_idle_on_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
endmodule

bind char_stream_fetch csf_checker #(.DW(DW)) i_csf_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .exhausted_o(exhausted_o),
  .char_o(char_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o)
);

// File: tb/test_char_stream_fetch.sv
`timescale 1ns/1ps
module test_char_stream_fetch;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, fold = 1'b0;
  logic [AW-1:0] base = '0;
  logic done, exh, req, we;
  logic [DW-1:0] chr, wdata, rdata;
  logic [AW-1:0] addr;

  always #4 clk = ~clk;

  char_stream_fetch #(.AW(AW), .DW(DW)) i_char_stream_fetch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base), .fold_i(fold),
    .done_o(done), .exhausted_o(exh), .char_o(chr),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata)
  );

  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (req && we) mem[addr[7:0]] <= wdata;
    if (req && !we) rdata <= mem[addr[7:0]];
  end

  int checks = 0, errors = 0, dones = 0, writes = 0;
  logic [16:0] exp_q[$];
  bit finished = 0;

  task automatic check(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, expv);
    end
  endtask

  // monitor: pops scoreboard on each done pulse
  always @(negedge clk) begin
    if (rst_n && we && req) writes++;
    if (rst_n && done) begin
      dones++;
      if (exp_q.size() == 0) check(0, "R9 unexpected done", 32'(chr), 0);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        check(exh == e[16], "R3 exhausted flag", 32'(exh), 32'(e[16]));
        check(chr == e[15:0], "R5/R7/R8 char", 32'(chr), 32'(e[15:0]));
      end
    end
  end

  task automatic wait_done(input int d0);
    int n = 0;
    while (dones == d0 && n < 50) begin @(negedge clk); n++; end
    if (dones == d0) check(0, "R9 no done", 0, 1);
  endtask

  task automatic run_op(input logic [7:0] b, input logic [15:0] w0, input logic [15:0] w1,
                        input logic [15:0] data, input bit f, input bit poke_busy);
    logic [7:0] by;
    logic [15:0] e_w0, e_w1;
    bit e_exh;
    int d0, wr0;
    mem[b] = w0; mem[b+8'd1] = w1; mem[w1[7:0]] = data;
    e_exh = (w0[14:0] == 15'd0);
    by = w0[15] ? data[7:0] : data[15:8];
    if (f && by >= 8'h61 && by <= 8'h7A) by = by - 8'h20;
    e_w0 = e_exh ? w0 : {~w0[15], w0[14:0] - 15'd1};
    e_w1 = (!e_exh && w0[15]) ? w1 + 16'd1 : w1;
    exp_q.push_back(e_exh ? 17'h10000 : {1'b0, 8'h00, by});
    d0 = dones; wr0 = writes;
    base = {8'h00, b}; fold = f; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_busy) begin
      mem[8'hF0] = 16'h0005; mem[8'hF1] = 16'h00F8;
      @(negedge clk); base = 16'h00F0; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait_done(d0);
    repeat (3) @(negedge clk);
    check(mem[b] == e_w0, "R4 word0 writeback", 32'(mem[b]), 32'(e_w0));
    check(mem[b+8'd1] == e_w1, "R6 word1 writeback", 32'(mem[b+8'd1]), 32'(e_w1));
    check(writes - wr0 == (e_exh ? 0 : (w0[15] ? 2 : 1)), "R3/R6 write count",
          32'(writes - wr0), 32'(e_exh ? 0 : (w0[15] ? 2 : 1)));
    if (poke_busy) begin
      check(dones == d0 + 1, "R9 busy start ignored", 32'(dones), 32'(d0 + 1));
      check(mem[8'hF0] == 16'h0005, "R9 other descriptor untouched", 32'(mem[8'hF0]), 32'h5);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && req == 1'b0, "R1 reset outputs", 32'({done, req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 empty stream, both flag values
    run_op(8'h10, 16'h0000, 16'h0040, 16'h4142, 0, 0);
    run_op(8'h12, 16'h8000, 16'h0040, 16'h4142, 0, 0);
    // R5 upper byte, R6 no word1 write
    run_op(8'h14, 16'h0003, 16'h0041, 16'h4A4B, 0, 0);
    // R5 lower byte, R6 word1 increment
    run_op(8'h16, 16'h8003, 16'h0042, 16'h4A4B, 0, 0);
    // R4 count 1 and max count
    run_op(8'h18, 16'h0001, 16'h0043, 16'h7A00, 0, 0);
    run_op(8'h1A, 16'hFFFF, 16'h0044, 16'h0061, 1, 0);
    // R7 fold boundaries
    run_op(8'h1C, 16'h0002, 16'h0045, 16'h617A, 1, 0);
    run_op(8'h1E, 16'h8002, 16'h0046, 16'h617A, 1, 0);
    run_op(8'h20, 16'h0002, 16'h0047, 16'h607B, 1, 0);
    run_op(8'h22, 16'h8002, 16'h0048, 16'h607B, 1, 0);
    run_op(8'h24, 16'h0002, 16'h0049, 16'h6162, 0, 0);
    // R8 high byte value
    run_op(8'h26, 16'h0002, 16'h004A, 16'hFF80, 1, 0);
    // R9 start while busy
    run_op(8'h28, 16'h8004, 16'h004B, 16'h1234, 0, 1);
    // R2 walk one stream: "hiX" across words 0x50,0x51 then empty
    begin
      logic [15:0] s0, s1;
      mem[8'h50] = 16'h6869; mem[8'h51] = 16'h5800;
      mem[8'h30] = 16'h0003; mem[8'h31] = 16'h0050;
      for (int k = 0; k < 4; k++) begin
        s0 = mem[8'h30]; s1 = mem[8'h31];
        run_op(8'h30, s0, s1, mem[s1[7:0]], 1, 0);
      end
      check(mem[8'h31] == 16'h0051, "R2 stream address advance", 32'(mem[8'h31]), 32'h51);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule